// File: doc/BRIEF.md
# Rotating single-edge bang-bang phase detector

This block is the digital decision stage of a quarter-rate bang-bang phase detector. Every cycle of the quarter-rate clock it receives eight one-bit samples of the incoming serial stream. The even sample positions hold data samples and the odd positions hold edge samples taken between them. A four-detector design would judge all four data-edge-data groups in parallel and sum the votes. This block judges only one group per cycle and time-shares a single decision unit across the four edge positions.

The group in use is chosen by a one-hot lane select. A divide-by-32 enable advances a small lane counter, and a decoder turns that counter into the select, so the lane moves round-robin 0, 1, 2, 3, 0 once every 32 cycles. The group at the top of the word spans a cycle boundary, so its two older bits are held in a register for one cycle. The decision is registered. It is presented as separate early and late pulses and as a signed code scaled by 4. That code keeps the same loop gain as a four-detector sum, and it feeds a digital loop filter or a charge-pump model downstream.

Top module: `rot_phase_judge`

## Requirements
- R1: A synchronous active-high reset sets the lane select to lane 0 (sel_o = 4'b0001), clears early_o, late_o and code_o, and restarts the divide-by-32 count. The reset also clears the held bits for lane 3.
- R2: At all times after reset, exactly one bit of sel_o is high.
- R3: The lane select steps in the fixed order lane 0, 1, 2, 3, then back to lane 0. Bit k of sel_o marks lane k.
- R4: The lane select changes exactly once every 32 clock cycles. The first change comes after the 32nd rising edge following reset release.
- R5: Sample bit 2k is a data sample and bit 2k+1 is an edge sample. Lane k (k = 0..2) judges the triplet (first data, edge, second data) = (bit 2k, bit 2k+1, bit 2k+2) of the current word. Lane 3 judges (bit 6 and bit 7 of the previous cycle's word, bit 0 of the current word).
- R6: When the two data samples of the selected triplet are equal, code_o is 0 and neither early_o nor late_o is high.
- R7: When the two data samples differ and the edge sample differs from the first data sample, late_o is high, early_o is low and code_o is +4.
- R8: When the two data samples differ and the edge sample equals the first data sample, early_o is high, late_o is low and code_o is -4.
- R9: The decision is registered. Samples held before rising edge n, judged under the lane that is selected before that edge, set the outputs that appear after edge n.
- R10: The sample bits that are not in the selected triplet have no effect on early_o, late_o or code_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Quarter-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_i | input | 8 | Sample word; even bits are data, odd bits are edges |
| sel_o | output | 4 | One-hot lane select currently in use |
| early_o | output | 1 | Clock-early decision, one cycle wide |
| late_o | output | 1 | Clock-late decision, one cycle wide |
| code_o | output | 4 | Signed scaled decision: -4, 0 or +4 |

## Verification
The bench sweeps over a thousand varied sample words through eight full rotations, so every lane sees all eight triplet values. A wrong bit mapping in a lane produces decisions that belong to a neighbouring group. The lane-3 wraparound is the sharpest corner: a design that took bits 6 and 7 from the current word instead of the previous one would disagree whenever they change between cycles. The rotation boundary is checked cycle by cycle, so a divider that is off by one drifts against the 32-cycle model within one rotation. A reset in the middle of lane 2 must bring the select back to lane 0 and restart the full 32-cycle count.

// File: rtl/rpj_pkg.sv
package rpj_pkg;

  typedef enum logic [1:0] {
    JUDGE_HOLD  = 2'd0,
    JUDGE_EARLY = 2'd1,
    JUDGE_LATE  = 2'd2
  } judge_e;

  // Alexander-style vote on one data-edge-data triplet
  function automatic judge_e judge(input logic da, input logic de, input logic db);
    if (da == db)      return JUDGE_HOLD;
    else if (de != da) return JUDGE_LATE;
    else               return JUDGE_EARLY;
  endfunction

  // Signed scaled vote for the loop filter
  function automatic int scaled(input judge_e j, input int gain);
    case (j)
      JUDGE_LATE:  return gain;
      JUDGE_EARLY: return -gain;
      default:     return 0;
    endcase
  endfunction

endpackage

// File: rtl/rpj_rotor.sv
module rpj_rotor #(
  parameter int LANES = 4,
  parameter int DIV   = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LANES-1:0] sel_o,
  output logic             wrap_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [DW-1:0] div_q;
  logic [IW-1:0] idx_q;
  logic [LANES-1:0] sel_rot;

  assign wrap_o = (div_q == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      idx_q <= '0;
    end else if (wrap_o) begin
      div_q <= '0;
      idx_q <= (idx_q == IW'(LANES - 1)) ? '0 : idx_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // 2-to-4 style decoder, one line per lane
  for (genvar k = 0; k < LANES; k++) begin : g_dec
    assign sel_o[k] = (idx_q == IW'(k));
  end

  assign sel_rot = {sel_o[LANES-2:0], sel_o[LANES-1]};

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_o) == 1);

  a_r3_rotate_order: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_o) |-> sel_o == $past(sel_rot));

  a_r4_change_on_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_o) |-> $past(wrap_o));

  a_r4_wrap_moves: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !$stable(sel_o));

endmodule

// File: rtl/rpj_pick.sv
module rpj_pick #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*LANES-1:0] samp_i,
  input  logic [LANES-1:0]   sel_i,
  output logic               da_o,
  output logic               de_o,
  output logic               db_o
);
  localparam int NS = 2 * LANES;

  logic prev_d_q, prev_e_q;
  logic [LANES-1:0] lane_da, lane_de, lane_db;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_d_q <= 1'b0;
      prev_e_q <= 1'b0;
    end else begin
      prev_d_q <= samp_i[NS-2];
      prev_e_q <= samp_i[NS-1];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < LANES - 1) begin : g_inner
      assign lane_da[k] = samp_i[2*k];
      assign lane_de[k] = samp_i[2*k+1];
      assign lane_db[k] = samp_i[2*k+2];
    end else begin : g_wrap
      assign lane_da[k] = prev_d_q;
      assign lane_de[k] = prev_e_q;
      assign lane_db[k] = samp_i[0];
    end
  end

  assign da_o = |(lane_da & sel_i);
  assign de_o = |(lane_de & sel_i);
  assign db_o = |(lane_db & sel_i);

  a_r5_wrap_uses_held: assert property (@(posedge clk) disable iff (rst)
    sel_i[LANES-1] && !$past(rst) |-> da_o == $past(samp_i[NS-2]) && de_o == $past(samp_i[NS-1]));

endmodule

// File: rtl/rpj_judge.sv
module rpj_judge #(
  parameter int GAIN   = 4,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     da_i,
  input  logic                     de_i,
  input  logic                     db_i,
  output logic                     early_o,
  output logic                     late_o,
  output logic signed [CODE_W-1:0] code_o
);
  import rpj_pkg::*;

  judge_e vote;
  assign vote = judge(da_i, de_i, db_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      early_o <= 1'b0;
      late_o  <= 1'b0;
      code_o  <= '0;
    end else begin
      early_o <= (vote == JUDGE_EARLY);
      late_o  <= (vote == JUDGE_LATE);
      code_o  <= CODE_W'(scaled(vote, GAIN));
    end
  end

  a_r6_hold_no_edge: assert property (@(posedge clk) disable iff (rst)
    $past(da_i == db_i) |-> code_o == 0 && !early_o && !late_o);

  a_r7_late_sign: assert property (@(posedge clk) disable iff (rst)
    late_o |-> code_o == CODE_W'(GAIN) && !early_o);

  a_r8_early_sign: assert property (@(posedge clk) disable iff (rst)
    early_o |-> code_o == CODE_W'(-GAIN) && !late_o);

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    $past(da_i != db_i && de_i == da_i) && !$past(rst) |-> early_o);

endmodule

// File: rtl/rot_phase_judge.sv
module rot_phase_judge #(
  parameter int LANES  = 4,
  parameter int DIV    = 32,
  parameter int GAIN   = 4,
  parameter int CODE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2*LANES-1:0]       samp_i,
  output logic [LANES-1:0]         sel_o,
  output logic                     early_o,
  output logic                     late_o,
  output logic signed [CODE_W-1:0] code_o
);
  logic wrap;
  logic da, de, db;

  rpj_rotor #(.LANES(LANES), .DIV(DIV)) u_rotor (
    .clk(clk), .rst(rst), .sel_o(sel_o), .wrap_o(wrap)
  );

  rpj_pick #(.LANES(LANES)) u_pick (
    .clk(clk), .rst(rst), .samp_i(samp_i), .sel_i(sel_o),
    .da_o(da), .de_o(de), .db_o(db)
  );

  rpj_judge #(.GAIN(GAIN), .CODE_W(CODE_W)) u_judge (
    .clk(clk), .rst(rst), .da_i(da), .de_i(de), .db_i(db),
    .early_o(early_o), .late_o(late_o), .code_o(code_o)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> sel_o == LANES'(1) && code_o == 0 && !early_o && !late_o);

endmodule

// File: tb/test_rot_phase_judge.sv
module test_rot_phase_judge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] samp_i = 8'h00;
  logic [3:0] sel_o;
  logic       early_o, late_o;
  logic signed [3:0] code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_div = 0;
  int m_lane = 0;
  logic m_p6 = 1'b0, m_p7 = 1'b0;

  always #10 clk = ~clk;

  rot_phase_judge i_rot_phase_judge (
    .clk(clk), .rst(rst), .samp_i(samp_i), .sel_o(sel_o),
    .early_o(early_o), .late_o(late_o), .code_o(code_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // four detectors side by side; each returns -1, 0 or +1
  function automatic int vote(input logic a, input logic e, input logic b);
    if (a == b) return 0;
    return (e != a) ? 1 : -1;
  endfunction

  task automatic do_reset(input int cycles);
    rst = 1'b1;
    repeat (cycles) @(negedge clk);
    m_div = 0; m_lane = 0; m_p6 = 1'b0; m_p7 = 1'b0;
    check(sel_o == 4'b0001, "R1 sel", sel_o, 1);
    check(code_o == 0, "R1 code", code_o, 0);
    check(!early_o && !late_o, "R1 pulses", {early_o, late_o}, 0);
    rst = 1'b0;
  endtask

  task automatic step(input logic [7:0] v);
    int votes[4];
    int exp;
    string tag;
    samp_i = v;
    votes[0] = vote(v[0], v[1], v[2]);
    votes[1] = vote(v[2], v[3], v[4]);
    votes[2] = vote(v[4], v[5], v[6]);
    votes[3] = vote(m_p6, m_p7, v[0]);
    exp = 4 * votes[m_lane];
    tag = (exp == 0) ? "R6" : (exp > 0) ? "R7" : "R8";
    if (m_lane == 3) tag = {tag, " R5"};
    @(negedge clk);
    m_p6 = v[6]; m_p7 = v[7];
    if (m_div == 31) begin m_div = 0; m_lane = (m_lane + 1) % 4; end
    else m_div++;
    check(code_o == exp, {tag, " R9 R10 code"}, code_o, exp);
    check(early_o == (exp < 0), {tag, " early"}, early_o, exp < 0);
    check(late_o == (exp > 0), {tag, " late"}, late_o, exp > 0);
    check(sel_o == (4'b0001 << m_lane), "R2 R3 R4 sel", sel_o, 1 << m_lane);
  endtask

  initial begin
    @(negedge clk);
    do_reset(3);
    for (int i = 0; i < 1024; i++)
      step(8'((i * 29 + (i >> 7) * 3) & 255));
    // reset while lane 2 is active
    for (int i = 0; i < 70; i++)
      step(8'((i * 113) ^ 8'h5a));
    do_reset(2);
    for (int i = 0; i < 300; i++)
      step(8'((i * 77 + 11) ^ (i >> 5)));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule